// File: doc/BRIEF.md
# Query Matcher and Timed Reply Serializer

This block sits behind a receive decoder that has already collected a reader frame. Each finished frame arrives as a bit count and two data bytes on a valid/ready input. The block compares the frame with a small built-in table of known queries. When one entry matches, the block sends that entry's fixed reply on a single serial line. The reply goes out least significant bit first, and each bit is held for a fixed number of divided-clock ticks. The first bit starts a fixed turnaround time after the frame was accepted.

All timing comes from one prescaler. `TICK_DIV` clock cycles make one tick. The turnaround is `START_TICKS` ticks, with a default of 490. One bit is `BIT_TICKS` ticks, with a default of 150. A frame that matches no entry is taken and dropped. Nothing is sent for it, and the block stays ready for the next frame.

Back-pressure rules: `frm_ready` stays high whenever no reply is in progress. A frame is taken on a rising clock edge where `frm_valid` and `frm_ready` are both high. A reply that starts pulls `frm_ready` low. It stays low until the last bit has ended and the line is back at low, so an upstream source has to hold its frame or drop it. Frames presented during that time are never taken.

Top module: `query_reply_engine`

## Requirements
- R1: Out of reset, `tx_line` is low, `busy` is low and `frm_ready` is high.
- R2: `frm_ready` is high exactly when `busy` is low. A frame is taken only on an edge where `frm_valid` and `frm_ready` are both high.
- R3: A frame matches an entry only if its bit count and both of its bytes equal that entry's values. Entry 0 matches 7 bits with byte0 0x55 and byte1 0x00, and its reply is 6 bits of 0x3B. Entry 1 matches 12 bits with bytes 0xC3 and 0x0A, and its reply is 11 bits taken from bytes 0x5A and 0x03.
- R4: After a matching frame is taken, `tx_line` stays low for START_TICKS*TICK_DIV cycles. It then takes the level of the first reply bit.
- R5: Each reply bit is held for BIT_TICKS*TICK_DIV cycles. The bits are sent starting at bit 0 of byte 0 and moving upward, with bit 7 of byte 0 followed by bit 0 of byte 1. A 1 drives the line high and a 0 drives it low.
- R6: Exactly as many bits as the reply length are sent. `tx_line` returns low and `busy` falls together, (START_TICKS + length*BIT_TICKS)*TICK_DIV cycles after the frame was taken.
- R7: A frame that matches no entry is taken. It leaves `busy` low and `tx_line` low.
- R8: A frame presented while a reply is in progress is not taken. It does not change the reply in progress, and it causes no reply afterwards.
- R9: `busy` is high in the cycle after a matching frame is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | A finished frame is offered |
| frm_ready | output | 1 | The block can take a frame |
| frm_bits | input | 8 | Number of valid bits in the frame |
| frm_byte0 | input | 8 | First data byte, first bit received in bit 0 |
| frm_byte1 | input | 8 | Second data byte |
| tx_line | output | 1 | Serial reply output |
| busy | output | 1 | A reply is pending or being sent |

## Verification
Both table entries are sent with their exact bit count and bytes, and the bench checks the line at the first and last cycle of every bit. This separates an off-by-one in the turnaround or bit period from a wrong bit order. Near-miss frames are also sent. One has the right byte0 but a bit count one too high, and one has the right count but a nonzero byte1. These show whether the count and both bytes all take part in the comparison. A second matching frame is held up while a reply is in progress, to show that it is refused and does not extend or change the reply.

// File: rtl/qre_pkg.sv
package qre_pkg;

  localparam int NUM_ENTRIES = 2;
  localparam int DATA_BITS   = 16;

  typedef struct packed {
    logic [7:0]           q_len;
    logic [7:0]           q_b0;
    logic [7:0]           q_b1;
    logic [7:0]           r_len;
    logic [DATA_BITS-1:0] r_data;
  } entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } sstate_e;

  function automatic entry_t table_entry(input int idx);
    entry_t e;
    e = '0;
    case (idx)
      0: begin
        e.q_len  = 8'd7;
        e.q_b0   = 8'h55;
        e.q_b1   = 8'h00;
        e.r_len  = 8'd6;
        e.r_data = 16'h003B;
      end
      1: begin
        e.q_len  = 8'd12;
        e.q_b0   = 8'hC3;
        e.q_b1   = 8'h0A;
        e.r_len  = 8'd11;
        e.r_data = 16'h035A;
      end
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/qre_matcher.sv
module qre_matcher
  import qre_pkg::*;
#(
  parameter int N_ENT = NUM_ENTRIES
) (
  input  logic [7:0] bits_in,
  input  logic [7:0] b0_in,
  input  logic [7:0] b1_in,
  output logic       hit,
  output entry_t     sel
);

  logic [N_ENT-1:0] hv;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    localparam entry_t ENT = table_entry(g);
    assign hv[g] = (bits_in == ENT.q_len) && (b0_in == ENT.q_b0) &&
                   (b1_in == ENT.q_b1) && (ENT.r_len != 8'd0);
  end

  // lowest index wins if entries ever overlap
  always_comb begin
    sel = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (hv[k]) sel = table_entry(k);
    end
  end

  assign hit = |hv;

endmodule

// File: rtl/qre_ticker.sv
module qre_ticker #(
  parameter int DIV = 32,
  parameter int CW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic          tick,
  output logic [CW-1:0] count
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;

  assign tick = run && (pre == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      count <= '0;
    end else if (clear) begin
      pre   <= '0;
      count <= '0;
    end else if (run) begin
      if (tick) begin
        pre   <= '0;
        count <= count + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

endmodule

// File: rtl/qre_serializer.sv
module qre_serializer
  import qre_pkg::*;
#(
  parameter int START_TICKS = 490,
  parameter int BIT_TICKS   = 150,
  parameter int CW          = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [7:0]           len_in,
  input  logic [DATA_BITS-1:0] data_in,
  input  logic                 tick,
  input  logic [CW-1:0]        tcount,
  output logic                 clear,
  output logic                 run,
  output logic                 line,
  output logic                 active
);

  localparam int IW = $clog2(DATA_BITS + 1);

  sstate_e              st;
  logic [DATA_BITS-1:0] data_q;
  logic [IW-1:0]        idx_q;
  logic [IW-1:0]        last_q;
  logic                 wait_done;
  logic                 bit_done;

  assign wait_done = (st == ST_WAIT) && tick && (tcount == CW'(START_TICKS - 1));
  assign bit_done  = (st == ST_SEND) && tick && (tcount == CW'(BIT_TICKS - 1));
  assign clear     = start || wait_done || bit_done;
  assign run       = (st != ST_IDLE);
  assign active    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      data_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
      line   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          line <= 1'b0;
          if (start) begin
            data_q <= data_in;
            last_q <= IW'(len_in - 8'd1);
            idx_q  <= '0;
            st     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            line <= data_q[0];
            st   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (bit_done) begin
            if (idx_q == last_q) begin
              line <= 1'b0;
              st   <= ST_IDLE;
            end else begin
              line  <= data_q[idx_q + 1'b1];
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/query_reply_engine.sv
module query_reply_engine
  import qre_pkg::*;
#(
  parameter int TICK_DIV    = 32,
  parameter int START_TICKS = 490,
  parameter int BIT_TICKS   = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_valid,
  output logic       frm_ready,
  input  logic [7:0] frm_bits,
  input  logic [7:0] frm_byte0,
  input  logic [7:0] frm_byte1,
  output logic       tx_line,
  output logic       busy
);

  localparam int TMAX = (START_TICKS > BIT_TICKS) ? START_TICKS : BIT_TICKS;
  localparam int CW   = $clog2(TMAX + 1);

  logic          accept;
  logic          match_hit;
  entry_t        match_ent;
  logic          tk_clear;
  logic          tk_run;
  logic          tk_tick;
  logic [CW-1:0] tk_count;
  logic          ser_active;

  assign frm_ready = !ser_active;
  assign accept    = frm_valid && frm_ready;
  assign busy      = ser_active;

  qre_matcher #(.N_ENT(NUM_ENTRIES)) u_match (
    .bits_in (frm_bits),
    .b0_in   (frm_byte0),
    .b1_in   (frm_byte1),
    .hit     (match_hit),
    .sel     (match_ent)
  );

  qre_ticker #(.DIV(TICK_DIV), .CW(CW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tk_clear),
    .run   (tk_run),
    .tick  (tk_tick),
    .count (tk_count)
  );

  qre_serializer #(
    .START_TICKS (START_TICKS),
    .BIT_TICKS   (BIT_TICKS),
    .CW          (CW)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept && match_hit),
    .len_in  (match_ent.r_len),
    .data_in (match_ent.r_data),
    .tick    (tk_tick),
    .tcount  (tk_count),
    .clear   (tk_clear),
    .run     (tk_run),
    .line    (tx_line),
    .active  (ser_active)
  );

endmodule

// File: rtl/qre_checker.sv
module qre_checker (
  input logic clk,
  input logic rst_n,
  input logic frm_valid,
  input logic frm_ready,
  input logic tx_line,
  input logic busy,
  input logic hit
);

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_line); // R6

  AST_BUSY_FALL_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !tx_line); // R6

  AST_NO_TAKE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !frm_ready); // R8

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> frm_ready); // R2

  AST_MISS_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !hit) |=> !busy); // R7

  AST_HIT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && hit) |=> busy); // R9

endmodule

bind query_reply_engine qre_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .tx_line   (tx_line),
  .busy      (busy),
  .hit       (match_hit)
);

// File: tb/query_reply_engine_test.sv
`timescale 1ns/1ps
module query_reply_engine_test;

  localparam int DIV = 4;
  localparam int ST  = 10;
  localparam int BT  = 6;
  localparam int S   = ST * DIV;
  localparam int BD  = BT * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic       frm_ready;
  logic [7:0] frm_bits = '0;
  logic [7:0] frm_byte0 = '0;
  logic [7:0] frm_byte1 = '0;
  logic       tx_line;
  logic       busy;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int acc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  query_reply_engine #(
    .TICK_DIV(DIV), .START_TICKS(ST), .BIT_TICKS(BT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_bits(frm_bits), .frm_byte0(frm_byte0), .frm_byte1(frm_byte1),
    .tx_line(tx_line), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // wait until N edges after the accepting edge, sample at the negedge
  task automatic at_cycle(input int n);
    while (cyc < acc + n) @(negedge clk);
  endtask

  task automatic offer(input logic [7:0] nb, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    frm_bits = nb; frm_byte0 = b0; frm_byte1 = b1; frm_valid = 1'b1;
    @(negedge clk);
    acc = cyc;
    frm_valid = 1'b0;
  endtask

  task automatic expect_reply(input string tag, input int len, input logic [15:0] data);
    check("R9", {tag, " busy after take"}, busy, 1);
    check("R2", {tag, " ready low while busy"}, frm_ready, 0);
    at_cycle(S - 1);
    check("R4", {tag, " line low before first bit"}, tx_line, 0);
    for (int i = 0; i < len; i++) begin
      at_cycle(S + i * BD);
      check("R5", $sformatf("%s bit %0d start", tag, i), tx_line, data[i]);
      at_cycle(S + (i + 1) * BD - 1);
      check("R5", $sformatf("%s bit %0d end", tag, i), tx_line, data[i]);
    end
    check("R6", {tag, " busy on last bit"}, busy, 1);
    at_cycle(S + len * BD);
    check("R6", {tag, " line low after reply"}, tx_line, 0);
    check("R6", {tag, " busy low after reply"}, busy, 0);
    check("R2", {tag, " ready back"}, frm_ready, 1);
  endtask

  task automatic t_reset;
    check("R1", "line at reset", tx_line, 0);
    check("R1", "busy at reset", busy, 0);
    check("R1", "ready at reset", frm_ready, 1);
  endtask

  task automatic t_entry0;
    offer(8'd7, 8'h55, 8'h00);
    expect_reply("R3 entry0", 6, 16'h003B);
  endtask

  task automatic t_entry1;
    offer(8'd12, 8'hC3, 8'h0A);
    expect_reply("R3 entry1", 11, 16'h035A);
  endtask

  task automatic t_miss(input logic [7:0] nb, input logic [7:0] b0, input logic [7:0] b1,
                        input string tag);
    offer(nb, b0, b1);
    check("R7", {tag, " not busy"}, busy, 0);
    check("R7", {tag, " ready"}, frm_ready, 1);
    for (int n = 0; n < S + BD; n++) begin
      at_cycle(n);
      if (tx_line !== 1'b0 || busy !== 1'b0) begin
        check("R7", {tag, " line stays low"}, tx_line, 0);
        break;
      end
    end
    check("R7", {tag, " quiet at end"}, tx_line, 0);
  endtask

  task automatic t_busy_refuse;
    offer(8'd7, 8'h55, 8'h00);
    at_cycle(S + 2);
    frm_bits = 8'd12; frm_byte0 = 8'hC3; frm_byte1 = 8'h0A; frm_valid = 1'b1;
    check("R8", "ready low during reply", frm_ready, 0);
    at_cycle(S + BD);
    check("R8", "bit 1 unchanged", tx_line, 1);
    at_cycle(S + 2 * BD);
    check("R8", "bit 2 unchanged", tx_line, 0);
    frm_valid = 1'b0;
    at_cycle(S + 6 * BD);
    check("R8", "reply ends on time", busy, 0);
    at_cycle(S + 6 * BD + S + BD);
    check("R8", "no late reply busy", busy, 0);
    check("R8", "no late reply line", tx_line, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry0();
    t_entry1();
    t_miss(8'd8, 8'h55, 8'h00, "R3 count off");
    t_miss(8'd7, 8'h55, 8'h01, "R3 byte1 off");
    t_miss(8'd12, 8'hC3, 8'h0B, "R3 entry1 byte1 off");
    t_busy_refuse();
    t_entry1();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule